// File: doc/BRIEF.md
# Quadrature Position Decoder with Event Strobes

This block turns two quadrature phase lines and an index line into a position count and a revolution count. It is meant to sit after an external synchroniser and glitch filter. It flags several conditions:

- an illegal two-bit phase jump;
- a position that is off at the index pulse;
- a change of count direction;
- a wrap of the revolution count;
- a start event.

Three single-cycle strobes drive the counter from outside. The start strobe clears both counts and enables counting. The capture strobe snapshots the position. The direction-toggle strobe flips the direction, and only in timer mode. A one-cycle compare pulse is emitted when the position lands on a programmed value.

The software side is a plain synchronous port. A register write takes effect at the clock edge, and a read is combinational from `rd_addr`. The block has no streaming data path, so every pin is a plain level or a strobe, and there is no back-pressure.

Register map (4-bit address, 16-bit data):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | mode: bit 0 = timer mode, bit 1 = direction toggle allowed |
| 1 | read/write | top (largest position value) |
| 2 | read/write | compare value |
| 3 | write only, reads 0 | set mask bits |
| 4 | write only, reads 0 | clear mask bits |
| 5 | read only | mask |
| 6 | read only | status |
| 7 | write only, reads 0 | clear status bits |
| 8 | read only | capture register |
| 9 | read only | position |
| 10 | read only | revolution count |

All other addresses read 0. The status and mask bits are:

| Bit | Condition |
|---|---|
| 0 | revolution wrap |
| 1 | index mismatch |
| 2 | direction change |
| 3 | illegal phase jump |
| 4 | start event |

Top module: `quad_pos_decoder`

## Requirements
- R1: In quadrature mode, while running, the phase word {qa,qb} is a Gray sequence. Stepping 00→01→11→10→00 counts up by one per step, the reverse order counts down by one, and an unchanged word does not count.
- R2: In quadrature mode, while running, a sample in which both phase bits change does not count and sets status bit 3.
- R3: Counting up from top gives 0, and counting down from 0 gives top. Each such wrap moves the revolution count by one in the same direction, and a wrap of the revolution count itself (all ones to 0, or 0 to all ones) sets status bit 0.
- R4: On a rising edge of the index line while running, the position is compared with top when the direction is up, or with 1 when it is down. A mismatch sets status bit 1.
- R5: Status bit 2 is set whenever the count direction changes: in quadrature mode by a step against the held direction, in timer mode by an accepted toggle. The direction is up after reset.
- R6: Before the first start strobe nothing counts. A start strobe clears the position and revolution count to 0, enables counting from the next cycle, and sets status bit 4.
- R7: A capture strobe copies the position held in that cycle into the capture register.
- R8: In timer mode the position steps once per cycle while running, in the held direction, and the phase lines are ignored. The toggle strobe flips the direction only when mode bit 1 is set; otherwise it has no effect.
- R9: `cmp_evt` is high for the one cycle that follows a count step which left the position equal to the compare value.
- R10: A write to the set-mask address sets every mask bit written as 1. A write to the clear-mask address clears them. The mask address reads the mask back.
- R11: Status bits stay set whether or not they are masked, and clear only through a 1 written to the clear-status address. A new event in the same cycle as the clear leaves its bit set.
- R12: `irq` is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| qa | input | 1 | phase A (synchronised) |
| qb | input | 1 | phase B (synchronised) |
| qidx | input | 1 | index line |
| ev_start | input | 1 | start strobe |
| ev_capture | input | 1 | capture strobe |
| ev_toggle | input | 1 | direction-toggle strobe |
| cmp_evt | output | 1 | compare pulse |
| wr_en | input | 1 | register write enable |
| wr_addr | input | 4 | register write address |
| wr_data | input | DW | register write data |
| rd_addr | input | 4 | register read address |
| rd_data | output | DW | register read data |
| irq | output | 1 | interrupt request |

## Verification
The revolution-wrap flag is the hardest condition to reach, because it needs a full cycle of the revolution count. With top set to 3, the stimulus drives more than 64 legal up-steps in one run.

The index check is also awkward: the index edge must land exactly on the boundary position. The stimulus parks the phase at top before raising the index line, and then raises it again off the boundary. A behavioural model in the bench tracks every register and output cycle by cycle, so clear-versus-event collisions and timer-mode toggles are compared as they happen.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int NSTAT    = 5;
  localparam int ST_ROLL  = 0;
  localparam int ST_IDX   = 1;
  localparam int ST_DIR   = 2;
  localparam int ST_PHASE = 3;
  localparam int ST_START = 4;

  typedef enum logic [3:0] {
    A_MODE = 4'd0,
    A_TOP  = 4'd1,
    A_CMP  = 4'd2,
    A_MSET = 4'd3,
    A_MCLR = 4'd4,
    A_MASK = 4'd5,
    A_STAT = 4'd6,
    A_SCLR = 4'd7,
    A_CAP  = 4'd8,
    A_POS  = 4'd9,
    A_REV  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/qd_phase.sv
module qd_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ph_i,
  output logic       step_o,
  output logic       up_o,
  output logic       bad_o
);
  logic [1:0] prev_q;

  function automatic logic [1:0] gray_pos(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  logic [1:0] delta;
  assign delta  = gray_pos(ph_i) - gray_pos(prev_q);
  assign step_o = delta[0];
  assign up_o   = (delta == 2'd1);
  assign bad_o  = (delta == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ph_i;
  end
endmodule

// File: rtl/qd_counter.sv
module qd_counter #(
  parameter int PW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          dir_i,
  input  logic          idx_i,
  input  logic          cap_i,
  input  logic [PW-1:0] top_i,
  input  logic [PW-1:0] cmp_i,
  output logic [PW-1:0] pos_o,
  output logic [RW-1:0] rev_o,
  output logic [PW-1:0] cap_o,
  output logic          roll_ev_o,
  output logic          idx_ev_o,
  output logic          cmp_ev_o
);
  localparam logic [RW-1:0] REV_MAX = {RW{1'b1}};
  localparam logic [PW-1:0] ONE     = PW'(1);

  logic          idx_q;
  logic [PW-1:0] pos_nxt;
  logic [RW-1:0] rev_nxt;
  logic          wrap;

  always_comb begin
    pos_nxt = pos_o;
    rev_nxt = rev_o;
    wrap    = 1'b0;
    if (up_i) begin
      if (pos_o == top_i) begin
        pos_nxt = '0;
        rev_nxt = rev_o + 1'b1;
        wrap    = 1'b1;
      end else begin
        pos_nxt = pos_o + ONE;
      end
    end else begin
      if (pos_o == '0) begin
        pos_nxt = top_i;
        rev_nxt = rev_o - 1'b1;
        wrap    = 1'b1;
      end else begin
        pos_nxt = pos_o - ONE;
      end
    end
  end

  assign roll_ev_o = step_i && !start_i && wrap &&
                     (up_i ? (rev_o == REV_MAX) : (rev_o == '0));
  assign idx_ev_o  = run_i && idx_i && !idx_q &&
                     (pos_o != (dir_i ? top_i : ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o    <= '0;
      rev_o    <= '0;
      cap_o    <= '0;
      idx_q    <= 1'b0;
      cmp_ev_o <= 1'b0;
    end else begin
      idx_q    <= idx_i;
      cmp_ev_o <= 1'b0;
      if (cap_i) cap_o <= pos_o;
      if (start_i) begin
        pos_o <= '0;
        rev_o <= '0;
      end else if (step_i) begin
        pos_o    <= pos_nxt;
        rev_o    <= rev_nxt;
        cmp_ev_o <= (pos_nxt == cmp_i);
      end
    end
  end

  p_capture_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> cap_o == $past(pos_o));
  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pos_o == '0) && (rev_o == '0));
endmodule

// File: rtl/qd_irq.sv
module qd_irq
  import qd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NSTAT-1:0] ev_i,
  output logic [NSTAT-1:0] mask_o,
  output logic [NSTAT-1:0] stat_o,
  output logic             irq_o
);
  logic [NSTAT-1:0] wbits, set_m, clr_m, clr_s;
  assign wbits = wr_data[NSTAT-1:0];
  assign set_m = (wr_en && wr_addr == A_MSET) ? wbits : '0;
  assign clr_m = (wr_en && wr_addr == A_MCLR) ? wbits : '0;
  assign clr_s = (wr_en && wr_addr == A_SCLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_o <= (mask_o | set_m) & ~clr_m;
      stat_o <= (stat_o & ~clr_s) | ev_i;
      irq_o  <= |(((stat_o & ~clr_s) | ev_i) & ((mask_o | set_m) & ~clr_m));
    end
  end

  p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((mask_o & $past(set_m)) == $past(set_m)));
  p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != '0) |=> ((mask_o & $past(clr_m)) == '0));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s == '0) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((stat_o & $past(ev_i)) == $past(ev_i)));
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qd_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qa,
  input  logic          qb,
  input  logic          qidx,
  input  logic          ev_start,
  input  logic          ev_capture,
  input  logic          ev_toggle,
  output logic          cmp_evt,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [1:0]    mode_q;
  logic [DW-1:0] top_q, cmpv_q;
  logic          run_q, dir_q;
  logic          ph_step, ph_up, ph_bad;
  logic          tmode, tog_ok;
  logic          cnt_step, cnt_up;
  logic          perr_ev, dir_ev, roll_ev, idx_ev;
  logic [DW-1:0] pos, cap;
  logic [RW-1:0] rev;
  logic [NSTAT-1:0] ev_vec, mask, stat;

  assign tmode  = mode_q[0];
  assign tog_ok = mode_q[1];

  qd_phase u_phase (
    .clk(clk), .rst_n(rst_n), .ph_i({qa, qb}),
    .step_o(ph_step), .up_o(ph_up), .bad_o(ph_bad)
  );

  assign cnt_step = run_q && (tmode || ph_step);
  assign cnt_up   = tmode ? dir_q : ph_up;
  assign perr_ev  = run_q && !tmode && ph_bad;
  assign dir_ev   = tmode ? (ev_toggle && tog_ok)
                          : (run_q && ph_step && (ph_up != dir_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      top_q  <= '1;
      cmpv_q <= '0;
      run_q  <= 1'b0;
      dir_q  <= 1'b1;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[1:0];
      if (wr_en && wr_addr == A_TOP)  top_q  <= wr_data;
      if (wr_en && wr_addr == A_CMP)  cmpv_q <= wr_data;
      if (ev_start) run_q <= 1'b1;
      if (dir_ev) dir_q <= ~dir_q;
    end
  end

  qd_counter #(.PW(DW), .RW(RW)) u_count (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .start_i(ev_start),
    .step_i(cnt_step), .up_i(cnt_up), .dir_i(dir_q), .idx_i(qidx),
    .cap_i(ev_capture), .top_i(top_q), .cmp_i(cmpv_q),
    .pos_o(pos), .rev_o(rev), .cap_o(cap),
    .roll_ev_o(roll_ev), .idx_ev_o(idx_ev), .cmp_ev_o(cmp_evt)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[ST_ROLL]  = roll_ev;
    ev_vec[ST_IDX]   = idx_ev;
    ev_vec[ST_DIR]   = dir_ev;
    ev_vec[ST_PHASE] = perr_ev;
    ev_vec[ST_START] = ev_start;
  end

  qd_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_i(ev_vec), .mask_o(mask), .stat_o(stat),
    .irq_o(irq)
  );

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = DW'(mode_q);
      A_TOP:   rd_data = top_q;
      A_CMP:   rd_data = cmpv_q;
      A_MASK:  rd_data = DW'(mask);
      A_STAT:  rd_data = DW'(stat);
      A_CAP:   rd_data = cap;
      A_POS:   rd_data = pos;
      A_REV:   rd_data = DW'(rev);
      default: rd_data = '0;
    endcase
  end

  p_bad_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    perr_ev |=> stat[ST_PHASE]);
  p_index_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ev |=> stat[ST_IDX]);
  p_toggle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && !tog_ok) |=> (dir_q == $past(dir_q)));
  p_irq_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & mask) != '0));
endmodule

// File: tb/quad_pos_decoder_bench.sv
`timescale 1ns/100ps
module quad_pos_decoder_bench;
  localparam int DW = 16;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qa = 0, qb = 0, qidx = 0, ev_start = 0, ev_capture = 0, ev_toggle = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 9;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic cmp_evt, irq;

  always #2.5 clk = ~clk;

  quad_pos_decoder #(.DW(DW), .RW(RW)) u_quad_pos_decoder (
    .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb), .qidx(qidx),
    .ev_start(ev_start), .ev_capture(ev_capture), .ev_toggle(ev_toggle),
    .cmp_evt(cmp_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  int m_mode, m_top, m_cmpv, m_pos, m_rev, m_cap, m_dir, m_run, m_prev, m_idxq;
  int m_mask, m_stat, m_cmpe, m_irq;
  int gseq[4] = '{0, 1, 3, 2};
  int cur_i = 0;

  function automatic int gi(int v);
    for (int k = 0; k < 4; k++) if (gseq[k] == v) return k;
    return 0;
  endfunction

  function automatic int mread(int a);
    case (a)
      0: return m_mode; 1: return m_top; 2: return m_cmpv;
      5: return m_mask; 6: return m_stat; 8: return m_cap;
      9: return m_pos; 10: return m_rev;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      5: return "R10"; 6: return "R11"; 8: return "R7";
      9: return "R1"; 10: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_top = 16'hFFFF; m_cmpv = 0; m_pos = 0; m_rev = 0; m_cap = 0;
      m_dir = 1; m_run = 0; m_prev = 0; m_idxq = 0; m_mask = 0; m_stat = 0;
      m_cmpe = 0; m_irq = 0;
    end else begin
      int cur, d, tm, tg, stp, upv, ev, npos, nrev, ndir, clr;
      cur = {qa, qb};
      d   = (gi(cur) - gi(m_prev) + 4) % 4;
      tm  = m_mode & 1; tg = (m_mode >> 1) & 1;
      stp = m_run && (tm || d == 1 || d == 3);
      upv = tm ? m_dir : (d == 1);
      ev = 0; npos = m_pos; nrev = m_rev; ndir = m_dir; m_cmpe = 0;
      if (!tm && m_run && d == 2) ev |= 8;
      if (tm) begin
        if (ev_toggle && tg) begin ndir = !m_dir; ev |= 4; end
      end else if (m_run && (d == 1 || d == 3)) begin
        if (upv != m_dir) ev |= 4;
        ndir = upv;
      end
      if (m_run && qidx && !m_idxq && m_pos != (m_dir ? m_top : 1)) ev |= 2;
      if (ev_start) begin
        npos = 0; nrev = 0; ev |= 16;
      end else if (stp) begin
        if (upv) begin
          if (m_pos == m_top) begin
            npos = 0; if (m_rev == 15) ev |= 1; nrev = (m_rev + 1) % 16;
          end else npos = (m_pos + 1) & 16'hFFFF;
        end else begin
          if (m_pos == 0) begin
            npos = m_top; if (m_rev == 0) ev |= 1; nrev = (m_rev + 15) % 16;
          end else npos = m_pos - 1;
        end
        m_cmpe = (npos == m_cmpv);
      end
      if (ev_capture) m_cap = m_pos;
      clr = 0;
      if (wr_en) case (wr_addr)
        0: m_mode = wr_data & 3;
        1: m_top = wr_data;
        2: m_cmpv = wr_data;
        3: m_mask = m_mask | (wr_data & 31);
        4: m_mask = m_mask & ~(wr_data & 31);
        7: clr = wr_data & 31;
        default: ;
      endcase
      m_stat = (m_stat & ~clr) | ev;
      m_irq  = ((m_stat & m_mask) != 0);
      m_pos = npos; m_rev = nrev; m_dir = ndir;
      if (ev_start) m_run = 1;
      m_prev = cur; m_idxq = qidx;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(rd_data == DW'(mread(rd_addr)), tag_of(rd_addr), rd_data, mread(rd_addr));
      chk(irq == m_irq[0], "R12", irq, m_irq);
      chk(cmp_evt == m_cmpe[0], "R9", cmp_evt, m_cmpe);
    end
  end

  task automatic drive(input int idx, input int st, input int cp, input int tg,
                       input int we, input int a, input int d);
    @(negedge clk);
    {qa, qb} = 2'(gseq[cur_i]);
    qidx = idx[0]; ev_start = st[0]; ev_capture = cp[0]; ev_toggle = tg[0];
    wr_en = we[0]; wr_addr = 4'(a); wr_data = DW'(d);
  endtask
  task automatic idle(input int n);
    repeat (n) drive(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input int a, input int d);
    drive(0, 0, 0, 0, 1, a, d);
  endtask
  task automatic steps(input int n, input int up);
    for (int k = 0; k < n; k++) begin
      cur_i = up ? (cur_i + 1) % 4 : (cur_i + 3) % 4;
      drive(0, 0, 0, 0, 0, 0, 0);
    end
  endtask
  task automatic probe(input int a, input int mask_bits, input int exp, input string req);
    @(negedge clk);
    {ev_start, ev_capture, ev_toggle, wr_en, qidx} = '0;
    rd_addr = 4'(a);
    #1;
    chk((int'(rd_data) & mask_bits) == exp, req, int'(rd_data) & mask_bits, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe(9, 16'hFFFF, 0, "R6 reset position");
    probe(1, 16'hFFFF, 16'hFFFF, "R3 reset top");
    // R6: no counting before start
    steps(3, 1);
    probe(9, 16'hFFFF, 0, "R6 idle before start");
    wr(1, 3); wr(2, 2); wr(3, 31);
    drive(0, 1, 0, 0, 0, 0, 0);
    probe(6, 16, 16, "R6 start flag");
    wr(7, 31);
    steps(3, 1);
    probe(9, 16'hFFFF, 3, "R1 counted up");
    drive(1, 0, 0, 0, 0, 0, 0); idle(1);
    probe(6, 2, 0, "R4 index at top ok");
    steps(2, 1);
    drive(1, 0, 0, 0, 0, 0, 0); idle(1);
    probe(6, 2, 2, "R4 index mismatch");
    wr(7, 31);
    steps(70, 1);
    probe(6, 1, 1, "R3 revolution wrap");
    wr(7, 31);
    steps(2, 0);
    probe(6, 4, 4, "R5 direction change");
    cur_i = (cur_i + 2) % 4;
    idle(1);
    probe(6, 8, 8, "R2 illegal jump");
    drive(0, 0, 1, 0, 0, 0, 0);
    probe(8, 16'hFFFF, m_pos, "R7 capture");
    wr(4, 31);
    probe(5, 31, 0, "R10 mask cleared");
    chk(irq == 1'b0, "R12 masked irq low", irq, 0);
    wr(3, 31);
    probe(5, 31, 31, "R10 mask set");
    drive(0, 1, 0, 0, 1, 7, 31);
    probe(6, 31, 16, "R11 event wins over clear");
    wr(7, 31);
    wr(0, 1); idle(5);
    drive(0, 0, 0, 1, 0, 0, 0); idle(2);
    probe(6, 4, 0, "R8 toggle ignored");
    wr(0, 3);
    drive(0, 0, 0, 1, 0, 0, 0); idle(6);
    probe(6, 4, 4, "R8 toggle accepted");
    wr(0, 0); idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule